// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four active-low modem input pins (carrier detect, ring indicator, data-set-ready, clear-to-send) and drives two active-low modem outputs (data-terminal-ready, request-to-send). Each input is brought into the clock domain by a two-flop synchronizer. The synchronized level is compared with its value one cycle earlier. A qualifying edge sets a sticky per-line change flag, which software clears by writing one to it.

The ring line is treated differently from the other three inputs. Its flag sets only when the ring signal goes from asserted to deasserted. Carrier, data-set-ready and clear-to-send flag a change on either edge.

While any flag is set, the block holds a combined delta event high for the interrupt logic. Software reaches the block through a single-cycle register port with a combinational read path. The port holds a modem control register and a modem status register. The status register also keeps a read/write flow-control mode bit.

Top module: `modem_delta_detect`

## Requirements
- R1: After reset, every status flag bit reads 0, the control register reads 0, the flow-mode bit reads 0, `dtr_n_o` and `rts_n_o` are 1, and `flow_auto_o` and `delta_irq_o` are 0.
- R2: Status bits 7, 6, 5 and 4 show the asserted state (pin low reads 1) of carrier, ring, data-set-ready and clear-to-send. A pin change passes through two flops: it is not visible one clock after it is applied and is visible after the second clock.
- R3: Status bits 3 (carrier), 1 (data-set-ready) and 0 (clear-to-send) set on either edge of the synchronized line and stay set until cleared.
- R4: Status bit 2 sets only when the ring line goes from asserted to deasserted. A ring assertion leaves it unchanged.
- R5: Writing the status register at offset 0x28 clears each of bits 3..0 whose write data bit is 1. Bits written 0 are unchanged.
- R6: When a new qualifying edge and a clearing write for the same flag occur in the same cycle, the flag stays set.
- R7: `delta_irq_o` is 1 exactly while at least one of status bits 3..0 is set.
- R8: The control register at offset 0x24 stores bit 0 (DTR), bit 1 (RTS) and bit 5 (automatic flow enable). Its other bits read 0. `dtr_n_o` and `rts_n_o` are the inverse of bits 0 and 1, and `flow_auto_o` equals bit 5.
- R9: Status bit 8 is a read/write flow-mode bit, written from write data bit 8 on any status write. Writing it does not affect bits 3..0.
- R10: Reads of any other offset return 0, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dcd_n_i | input | 1 | Carrier detect pin, active low, asynchronous |
| ri_n_i | input | 1 | Ring indicator pin, active low, asynchronous |
| dsr_n_i | input | 1 | Data-set-ready pin, active low, asynchronous |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i`, combinational |
| dtr_n_o | output | 1 | Data-terminal-ready pin, active low |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| flow_auto_o | output | 1 | Automatic flow-control enable |
| delta_irq_o | output | 1 | Combined modem-change event |

## Verification
If the previous-level register were wrong, a flag would be missed or would appear without a pin change. The status read would show this, and `delta_irq_o` would rise or fall wrongly, three clocks after the pin moves. A synchronizer with the wrong depth moves the level bits one clock early or late. The bench catches this by sampling after each of the first two clocks. A wrong priority between clear and set only shows when the clearing write lands on the exact cycle the edge is detected, so the bench aligns those two events directly.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int unsigned NUM_LINES = 4;
  // line index inside the level/flag vectors; equals status bit order
  localparam int unsigned LN_CTS = 0;
  localparam int unsigned LN_DSR = 1;
  localparam int unsigned LN_RI  = 2;
  localparam int unsigned LN_DCD = 3;
  // control register fields
  localparam int unsigned CB_DTR  = 0;
  localparam int unsigned CB_RTS  = 1;
  localparam int unsigned CB_AUTO = 5;
  // status register fields
  localparam int unsigned SB_FLAG = 0;
  localparam int unsigned SB_LVL  = SB_FLAG + NUM_LINES;
  localparam int unsigned SB_MODE = SB_LVL + NUM_LINES;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/modem_change_track.sv
module modem_change_track #(
  parameter int unsigned NUM      = 4,
  parameter int unsigned RING_IDX = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] lvl_i,
  input  logic [NUM-1:0] clr_i,
  output logic [NUM-1:0] flags_o
);
  logic [NUM-1:0] prev_q, flags_q, ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      flags_q <= '0;
    end else begin
      prev_q  <= lvl_i;
      flags_q <= (flags_q & ~clr_i) | ev; // set beats clear
    end
  end

  for (genvar k = 0; k < NUM; k++) begin : g_line
    if (k == RING_IDX) begin : g_trail
      assign ev[k] = prev_q[k] & ~lvl_i[k];

      p_ring_trail_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prev_q[k] && !lvl_i[k]) |=> flags_q[k]);
      p_ring_lead_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!prev_q[k] && lvl_i[k] && !flags_q[k]) |=> !flags_q[k]);
    end else begin : g_both
      assign ev[k] = prev_q[k] ^ lvl_i[k];

      p_any_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prev_q[k] != lvl_i[k]) |=> flags_q[k]);
    end

    p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_q[k] && !clr_i[k]) |=> flags_q[k]);
    p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !ev[k]) |=> !flags_q[k]);
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/modem_regs.sv
module modem_regs
  import modem_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h24,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h28
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [NUM_LINES-1:0] lvl_i,
  input  logic [NUM_LINES-1:0] flags_i,
  output logic [NUM_LINES-1:0] clr_o,
  output logic                 dtr_o,
  output logic                 rts_o,
  output logic                 flow_auto_o
);
  logic dtr_q, rts_q, auto_q, mode_q;
  logic wr_ctrl, wr_stat;
  logic unused_wdata;

  assign wr_ctrl = wr_i && (addr_i == CTRL_OFS);
  assign wr_stat = wr_i && (addr_i == STAT_OFS);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dtr_q  <= 1'b0;
      rts_q  <= 1'b0;
      auto_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        dtr_q  <= wdata_i[CB_DTR];
        rts_q  <= wdata_i[CB_RTS];
        auto_q <= wdata_i[CB_AUTO];
      end
      if (wr_stat) mode_q <= wdata_i[SB_MODE];
    end
  end

  assign clr_o = wr_stat ? wdata_i[SB_FLAG +: NUM_LINES] : '0;

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_OFS) begin
      rdata_o[CB_DTR]  = dtr_q;
      rdata_o[CB_RTS]  = rts_q;
      rdata_o[CB_AUTO] = auto_q;
    end else if (addr_i == STAT_OFS) begin
      rdata_o[SB_FLAG +: NUM_LINES] = flags_i;
      rdata_o[SB_LVL +: NUM_LINES]  = lvl_i;
      rdata_o[SB_MODE]              = mode_q;
    end
  end

  assign dtr_o       = dtr_q;
  assign rts_o       = rts_q;
  assign flow_auto_o = auto_q;

  p_ctrl_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (dtr_o == $past(wdata_i[CB_DTR])) && (rts_o == $past(wdata_i[CB_RTS]))
                && (flow_auto_o == $past(wdata_i[CB_AUTO])));
  p_mode_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat |=> (mode_q == $past(wdata_i[SB_MODE])));
  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ctrl && !wr_stat) |=> $stable(dtr_o) && $stable(rts_o) && $stable(flow_auto_o)
                               && $stable(mode_q));
endmodule

// File: rtl/modem_delta_detect.sv
module modem_delta_detect
  import modem_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SYNC_DEPTH = 2,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h24,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dcd_n_i,
  input  logic              ri_n_i,
  input  logic              dsr_n_i,
  input  logic              cts_n_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              dtr_n_o,
  output logic              rts_n_o,
  output logic              flow_auto_o,
  output logic              delta_irq_o
);
  logic [NUM_LINES-1:0] raw, lvl, flags, clr;
  logic dtr, rts;

  // pins are active low; internal levels are 1 when asserted
  always_comb begin
    raw         = '0;
    raw[LN_DCD] = ~dcd_n_i;
    raw[LN_RI]  = ~ri_n_i;
    raw[LN_DSR] = ~dsr_n_i;
    raw[LN_CTS] = ~cts_n_i;
  end

  modem_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_DEPTH)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(lvl)
  );

  modem_change_track #(.NUM(NUM_LINES), .RING_IDX(LN_RI)) u_track (
    .clk_i, .rst_ni, .lvl_i(lvl), .clr_i(clr), .flags_o(flags)
  );

  modem_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)
  ) u_regs (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .lvl_i(lvl), .flags_i(flags), .clr_o(clr),
    .dtr_o(dtr), .rts_o(rts), .flow_auto_o(flow_auto_o)
  );

  assign dtr_n_o     = ~dtr;
  assign rts_n_o     = ~rts;
  assign delta_irq_o = |flags;

  p_irq_needs_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!delta_irq_o && $stable(lvl)) |=> !delta_irq_o);
endmodule

// File: tb/modem_delta_detect_tb_top.sv
module modem_delta_detect_tb_top;
  localparam logic [7:0] CTRL = 8'h24;
  localparam logic [7:0] STAT = 8'h28;
  localparam int unsigned WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dcd_n = 1'b1, ri_n = 1'b1, dsr_n = 1'b1, cts_n = 1'b1;
  logic [7:0] addr = '0;
  logic wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic dtr_n, rts_n, flow_auto, irq;
  int checks = 0;
  int errors = 0;

  // {dcd_n, ri_n, dsr_n, cts_n} pins, then expected status[7:0]
  localparam logic [11:0] VEC [0:5] = '{12'h788, 12'hB48, 12'hF04,
                                        12'hC33, 12'h0F8, 12'hF0F};

  always #5 clk = ~clk;

  modem_delta_detect dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .dcd_n_i(dcd_n), .ri_n_i(ri_n), .dsr_n_i(dsr_n), .cts_n_i(cts_n),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .dtr_n_o(dtr_n), .rts_n_o(rts_n), .flow_auto_o(flow_auto), .delta_irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pins(input logic [3:0] p);
    @(negedge clk);
    {dcd_n, ri_n, dsr_n, cts_n} = p;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(WATCHDOG * 10);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    reg_rd(STAT, d); check("R1 status", d, 32'h0);
    reg_rd(CTRL, d); check("R1 ctrl", d, 32'h0);
    check("R1 pins", {dtr_n, rts_n, flow_auto, irq}, 4'b1100);

    // R3 R4 R7 table walk, then R5 clear after each step
    for (int v = 0; v < 6; v++) begin
      pins(VEC[v][11:8]);
      idle(5);
      reg_rd(STAT, d);
      check($sformatf("R3/R4 step %0d status", v), d, {24'h0, VEC[v][7:0]});
      check($sformatf("R7 step %0d irq", v), irq, |VEC[v][3:0]);
      reg_wr(STAT, 32'hF);
      reg_rd(STAT, d);
      check($sformatf("R5 step %0d cleared", v), d, {24'h0, VEC[v][7:4], 4'h0});
      check($sformatf("R7 step %0d irq low", v), irq, 1'b0);
    end

    // R2 two-stage synchronizer timing
    pins(4'b1110);
    @(negedge clk);
    reg_rd(STAT, d); check("R2 after one clock", d[4], 1'b0);
    @(negedge clk);
    reg_rd(STAT, d); check("R2 after two clocks", d[4], 1'b1);
    idle(3);
    // cts flag now set; R5 writing zero leaves it
    reg_wr(STAT, 32'h0);
    reg_rd(STAT, d); check("R5 write zero keeps flag", d[3:0], 4'h1);
    // R5 clearing another bit leaves cts flag
    reg_wr(STAT, 32'h2);
    reg_rd(STAT, d); check("R5 selective clear", d[3:0], 4'h1);
    reg_wr(STAT, 32'h1);
    reg_rd(STAT, d); check("R5 clear cts", d[3:0], 4'h0);

    // R6 edge and clear land in the same cycle
    pins(4'b1111);          // cts deasserts
    @(negedge clk);         // stage 1 captured
    @(negedge clk);         // level updated, edge pending
    addr = STAT; wdata = 32'h1; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    reg_rd(STAT, d); check("R6 set beats clear", d[0], 1'b1);
    idle(3);
    reg_rd(STAT, d); check("R6 flag still held", d[0], 1'b1);
    reg_wr(STAT, 32'h1);
    reg_rd(STAT, d); check("R6 plain clear", d[0], 1'b0);

    // R9 flow-mode bit
    reg_wr(STAT, 32'h100);
    reg_rd(STAT, d); check("R9 mode set", d, 32'h100);
    pins(4'b0111);
    idle(5);
    reg_wr(STAT, 32'h100);
    reg_rd(STAT, d); check("R9 mode write keeps flags", d, 32'h188);
    reg_wr(STAT, 32'h008);
    reg_rd(STAT, d); check("R9 mode cleared", d, 32'h080);
    pins(4'b1111);
    idle(5);
    reg_wr(STAT, 32'hF);

    // R8 control register
    reg_wr(CTRL, 32'h23);
    reg_rd(CTRL, d); check("R8 ctrl read", d, 32'h23);
    check("R8 ctrl pins", {dtr_n, rts_n, flow_auto}, 3'b001);
    reg_wr(CTRL, 32'hFFFF_FFFF);
    reg_rd(CTRL, d); check("R8 ctrl masked", d, 32'h23);
    reg_wr(CTRL, 32'h2);
    reg_rd(CTRL, d); check("R8 rts only", d, 32'h2);
    check("R8 rts only pins", {dtr_n, rts_n, flow_auto}, 3'b100);

    // R10 unmapped offset
    reg_wr(8'h2C, 32'hFFFF_FFFF);
    reg_rd(8'h2C, d); check("R10 unmapped read", d, 32'h0);
    reg_rd(CTRL, d); check("R10 ctrl untouched", d, 32'h2);
    reg_rd(STAT, d); check("R10 status untouched", d, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule